// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

This block is the control sequencer of a microprogrammed machine, built with two levels of read-only storage. A micro-program counter selects a narrow microword. A microword either redirects the micro-program counter (a micro-jump) or points into a wide nanoword store. The selected nanoword is expanded into a wide bundle of control lines. A control pattern that recurs across the micro-program is stored once, as a single nanoword, and every microword that needs it points at that entry.

An external decoder starts each instruction's micro-routine by strobing `dispatch` with the routine's entry address. The sequencer then steps through the routine on its own. `cond` is the datapath flag tested by conditional micro-jumps. Both stores are internal arrays filled at start-up with a computed test image, described in R9 and R10.

Top module: `nano_seq`

## Requirements
- R1: A synchronous `rst` sets `upc` to 0. In the cycle after reset, `ctrl` shows the decode of microword 0.
- R2: While `dispatch` is high, the next clock loads `upc` from `disp_addr`. This takes priority over any jump or step.
- R3: Microwords are 17 bits wide. Bit 16 set marks a jump word: bit 15 set makes it unconditional, and bits 9:0 hold the target. Bit 16 clear marks a nano word, with the nanoword pointer in bits 8:0.
- R4: A jump word whose jump is taken (unconditional, or `cond` high) loads `upc` with its target at the next clock.
- R5: A conditional jump word with `cond` low advances `upc` by one.
- R6: A nano word advances `upc` by one. The increment wraps from 1023 to 0.
- R7: In any cycle whose current microword is a jump word, all 196 bits of `ctrl` are 0.
- R8: A 68-bit nanoword N expands to `ctrl` in three parts. Bits 35:0 copy N[35:0]. For i = 0..3, the 3-bit field N[36+3i +: 3] sets exactly one bit among ctrl[36+8i +: 8], at the offset equal to the field value. For j = 0..3, the 5-bit field N[48+5j +: 5] sets exactly one bit among ctrl[68+32j +: 32], at the offset equal to the field value.
- R9: Microword a of the test image is a jump word when a mod 8 = 7. Such a word is unconditional when bit 3 of a is 0, and its target is a XOR 0x2A5. Every other microword is a nano word with pointer (5a+3) mod 512, so addresses a and a+512 share one nanoword.
- R10: Bit k of test nanoword p equals bit ((7k) mod 9) of p, inverted when k mod 3 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dispatch | input | 1 | Load `upc` from `disp_addr` |
| disp_addr | input | 10 | Entry address of the micro-routine |
| cond | input | 1 | Condition flag for conditional micro-jumps |
| ctrl | output | 196 | Decoded control bundle for the current microword |
| upc | output | 10 | Current micro-program counter |

## Verification
The assertions check the following on every cycle:
- a dispatch lands on its address;
- a taken jump lands on its target;
- any other cycle advances the counter by one;
- jump cycles drive no control lines;
- each decoded field of a nano cycle is exactly one-hot.

Only the bench scenarios can show the rest:
- the exact control bundle expected for every one of the 1024 microwords, built from the nanoword encoding;
- the sharing of one nanoword between two microwords;
- wrap-around at the top of the store;
- the reset value.

// File: rtl/nano_seq.sv
module nano_seq #(
  parameter int UPC_W = 10,
  parameter int PTR_W = 9,
  parameter int UW_W  = 17,
  parameter int DIR_W = 36,
  parameter int SF_N  = 4,
  parameter int SF_K  = 3,
  parameter int BF_N  = 4,
  parameter int BF_K  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dispatch,
  input  logic [UPC_W-1:0]    disp_addr,
  input  logic                cond,
  output logic [DIR_W+SF_N*(2**SF_K)+BF_N*(2**BF_K)-1:0] ctrl,
  output logic [UPC_W-1:0]    upc
);
  localparam int NW     = DIR_W + SF_N*SF_K + BF_N*BF_K;
  localparam int SF_D   = 2**SF_K;
  localparam int BF_D   = 2**BF_K;
  localparam int CW     = DIR_W + SF_N*SF_D + BF_N*BF_D;
  localparam int UDEPTH = 2**UPC_W;
  localparam int NDEPTH = 2**PTR_W;

  logic [UW_W-1:0] urom [UDEPTH];
  logic [NW-1:0]   nrom [NDEPTH];

  initial begin
    for (int a = 0; a < UDEPTH; a++) begin
      urom[a] = '0;
      if (a % 8 == 7) begin
        urom[a][UW_W-1]    = 1'b1;
        urom[a][UW_W-2]    = (((a >> 3) & 1) == 0);
        urom[a][UPC_W-1:0] = UPC_W'(a ^ 'h2A5);
      end else begin
        urom[a][PTR_W-1:0] = PTR_W'((5*a + 3) % NDEPTH);
      end
    end
    for (int p = 0; p < NDEPTH; p++)
      for (int k = 0; k < NW; k++)
        nrom[p][k] = 1'((p >> ((7*k) % PTR_W)) & 1) ^ (k % 3 == 0);
  end

  logic             is_jump, uncond;
  logic [UPC_W-1:0] tgt;
  logic [PTR_W-1:0] ptr;
  logic [NW-1:0]    nw;
  logic [CW-1:0]    dec;

  assign is_jump = urom[upc][UW_W-1];
  assign uncond  = urom[upc][UW_W-2];
  assign tgt     = urom[upc][UPC_W-1:0];
  assign ptr     = urom[upc][PTR_W-1:0];
  assign nw      = nrom[ptr];

  assign dec[DIR_W-1:0] = nw[DIR_W-1:0];
  for (genvar i = 0; i < SF_N; i++) begin : g_small
    assign dec[DIR_W + i*SF_D +: SF_D] =
      {{(SF_D-1){1'b0}}, 1'b1} << nw[DIR_W + i*SF_K +: SF_K];
  end
  for (genvar j = 0; j < BF_N; j++) begin : g_big
    assign dec[DIR_W + SF_N*SF_D + j*BF_D +: BF_D] =
      {{(BF_D-1){1'b0}}, 1'b1} << nw[DIR_W + SF_N*SF_K + j*BF_K +: BF_K];
  end

  assign ctrl = is_jump ? '0 : dec;

  always_ff @(posedge clk) begin
    if (rst)                             upc <= '0;
    else if (dispatch)                   upc <= disp_addr;
    else if (is_jump && (uncond || cond)) upc <= tgt;
    else                                 upc <= upc + 1'b1;
  end
endmodule

module nano_seq_chk #(
  parameter int UPC_W = 10,
  parameter int DIR_W = 36,
  parameter int SF_N  = 4,
  parameter int SF_K  = 3,
  parameter int BF_N  = 4,
  parameter int BF_K  = 5,
  parameter int CW    = 196
) (
  input logic             clk,
  input logic             rst,
  input logic             dispatch,
  input logic [UPC_W-1:0] disp_addr,
  input logic             cond,
  input logic [CW-1:0]    ctrl,
  input logic [UPC_W-1:0] upc,
  input logic             is_jump,
  input logic             uncond,
  input logic [UPC_W-1:0] tgt
);
  localparam int SF_D = 2**SF_K;
  localparam int BF_D = 2**BF_K;

  a_r2_dispatch: assert property (@(posedge clk) disable iff (rst)
    dispatch |=> upc == $past(disp_addr));

  a_r4_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (!dispatch && is_jump && (uncond || cond)) |=> upc == $past(tgt));

  a_r5_r6_step: assert property (@(posedge clk) disable iff (rst)
    (!dispatch && !(is_jump && (uncond || cond))) |=> upc == $past(upc) + 1'b1);

  a_r7_jump_quiet: assert property (@(posedge clk) disable iff (rst)
    is_jump |-> ctrl == '0);

  for (genvar i = 0; i < SF_N; i++) begin : g_sc
    a_r8_small_onehot: assert property (@(posedge clk) disable iff (rst)
      !is_jump |-> $countones(ctrl[DIR_W + i*SF_D +: SF_D]) == 1);
  end
  for (genvar j = 0; j < BF_N; j++) begin : g_bc
    a_r8_big_onehot: assert property (@(posedge clk) disable iff (rst)
      !is_jump |-> $countones(ctrl[DIR_W + SF_N*SF_D + j*BF_D +: BF_D]) == 1);
  end
endmodule

bind nano_seq nano_seq_chk #(
  .UPC_W(UPC_W), .DIR_W(DIR_W), .SF_N(SF_N), .SF_K(SF_K),
  .BF_N(BF_N), .BF_K(BF_K), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .dispatch(dispatch), .disp_addr(disp_addr),
  .cond(cond), .ctrl(ctrl), .upc(upc), .is_jump(is_jump),
  .uncond(uncond), .tgt(tgt)
);

// File: tb/test_nano_seq.sv
`timescale 1ns/1ps
module test_nano_seq;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dispatch = 1'b0;
  logic [9:0]   disp_addr = '0;
  logic         cond = 1'b0;
  logic [195:0] ctrl;
  logic [9:0]   upc;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  nano_seq i_nano_seq (
    .clk(clk), .rst(rst), .dispatch(dispatch), .disp_addr(disp_addr),
    .cond(cond), .ctrl(ctrl), .upc(upc)
  );

  always #4 clk = ~clk;

  function automatic logic [67:0] e_nano(int p);
    logic [67:0] r;
    for (int k = 0; k < 68; k++)
      r[k] = 1'((p >> ((7*k) % 9)) & 1) ^ (k % 3 == 0);
    return r;
  endfunction

  function automatic logic [195:0] e_ctrl(int a);
    logic [195:0] r;
    logic [67:0]  n;
    r = '0;
    if (a % 8 == 7) return r;
    n = e_nano((5*a + 3) % 512);
    r[35:0] = n[35:0];
    for (int i = 0; i < 4; i++) r[36 + 8*i + int'(n[36 + 3*i +: 3])] = 1'b1;
    for (int j = 0; j < 4; j++) r[68 + 32*j + int'(n[48 + 5*j +: 5])] = 1'b1;
    return r;
  endfunction

  function automatic int e_next(int a, bit c);
    if (a % 8 == 7 && (((a >> 3) & 1) == 0 || c)) return (a ^ 'h2A5) & 1023;
    return (a + 1) % 1024;
  endfunction

  task automatic check(bit ok, string req, logic [195:0] act, logic [195:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check(upc == 10'd0, "R1 upc after reset", 196'(upc), 196'(0));
    check(ctrl == e_ctrl(0), "R1 ctrl at address 0", ctrl, e_ctrl(0));

    // Sweep every microword with the flag low and high: R3..R10
    for (int a = 0; a < 1024; a++) begin
      for (int c = 0; c < 2; c++) begin
        @(negedge clk);
        dispatch = 1'b1; disp_addr = 10'(a); cond = c[0];
        @(negedge clk);
        dispatch = 1'b0;
        check(upc == 10'(a), "R2 dispatch load", 196'(upc), 196'(a));
        if (a % 8 == 7)
          check(ctrl == e_ctrl(a), "R7 jump cycle quiet", ctrl, e_ctrl(a));
        else
          check(ctrl == e_ctrl(a), "R8 R9 R10 nano decode", ctrl, e_ctrl(a));
        @(negedge clk);
        if (a % 8 == 7 && (((a >> 3) & 1) == 0 || c == 1))
          check(upc == 10'(e_next(a, c[0])), "R4 jump taken", 196'(upc), 196'(e_next(a, c[0])));
        else if (a % 8 == 7)
          check(upc == 10'(e_next(a, c[0])), "R5 jump not taken", 196'(upc), 196'(e_next(a, c[0])));
        else
          check(upc == 10'(e_next(a, c[0])), "R6 step and wrap", 196'(upc), 196'(e_next(a, c[0])));
      end
    end

    // R9: addresses 1 and 513 share one nanoword
    @(negedge clk) begin dispatch = 1'b1; disp_addr = 10'd1; end
    @(negedge clk) dispatch = 1'b0;
    begin
      logic [195:0] first;
      first = ctrl;
      @(negedge clk) begin dispatch = 1'b1; disp_addr = 10'd513; end
      @(negedge clk) dispatch = 1'b0;
      check(ctrl == first, "R9 shared nanoword", ctrl, first);
    end

    // R2: dispatch outranks a taken jump at address 15 (conditional, flag high)
    @(negedge clk) begin dispatch = 1'b1; disp_addr = 10'd15; cond = 1'b1; end
    @(negedge clk) begin dispatch = 1'b1; disp_addr = 10'd200; end
    @(negedge clk) dispatch = 1'b0;
    check(upc == 10'd200, "R2 dispatch priority", 196'(upc), 196'(200));

    // R1: reset in the middle of a routine
    @(negedge clk) begin dispatch = 1'b1; disp_addr = 10'd500; end
    @(negedge clk) begin dispatch = 1'b0; rst = 1'b1; end
    @(negedge clk) rst = 1'b0;
    check(upc == 10'd0, "R1 mid-run reset", 196'(upc), 196'(0));
    check(ctrl == e_ctrl(0), "R1 ctrl after mid-run reset", ctrl, e_ctrl(0));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule